// File: doc/BRIEF.md
# Floppy Controller Register Emulator

This block gives a host CPU the register view of a floppy disk controller on an 8-bit I/O bus. It has two ports: a main status port and a data port. Command bytes are written to the data port. The block counts them against a length that depends on the opcode. It then moves through command, execution and result phases and builds the status and result bytes the host software expects. No real medium is attached. Sector-ID records come from a side table that the block scans. Head movement is delegated to an external agent through a request/done handshake.

The phase machine has four states. `PH_CMD` collects command bytes. `PH_LOOKUP` runs while the ID scanner searches the side table; status reads there return 0x00. `PH_EXEC` counts data-port transfers. `PH_RESULT` hands out result bytes.

The named transitions are:
- CMD_TO_RESULT: the sense-interrupt command completes.
- CMD_TO_LOOKUP: a read data, write data or read ID command completes.
- LOOKUP_TO_EXEC: the scan ends for read data or write data.
- LOOKUP_TO_RESULT: the scan ends for read ID.
- EXEC_TO_RESULT: the last transfer byte is taken.
- EXEC_ABORT: a data-port read arrives in execution phase of a write command.
- RESULT_TO_CMD: the last result byte is read, or a sense interrupt is read while the seek is still pending.

Bus timing: a read drives its byte from the cycle after the falling edge of `iorq_n` until `iorq_n` is sampled high again.

Top module: `fdc_regs_emu`

## Requirements
- R1: An access is taken only on a falling edge of `iorq_n` when `addr[15:8]` equals 0xFB and `addr[10]` or `addr[8]` is low. `addr[0]`=0 selects the status port and `addr[0]`=1 selects the data port. Any other address, and any write to the status port, has no effect.
- R2: The opcode is the first command byte AND 0x1F. Lengths in bytes are:
  - specify 0x03: 3
  - recalibrate 0x07: 2
  - seek 0x0F: 3, with the cylinder in byte 2
  - sense interrupt 0x08: 1
  - read data 0x06 and write data 0x05: 9, with the record number R in byte 4
  - read ID 0x0A: 2

  After the last byte the byte index returns to 0. A first byte with any other opcode is ignored.
- R3: A status read returns 0x80 in PH_CMD, 0xD0 in PH_RESULT and 0x00 in PH_LOOKUP.
- R4: In PH_EXEC a status read returns 0x50 for read data and 0x10 for write data. The first status read after entry is plain. Every later status read has 0xA0 ORed in, giving 0xF0 or 0xB0.
- R5: Seek and recalibrate both do the same three things:
  - copy the current cylinder to `prev_cyl`
  - set the current cylinder to the new value (0 for recalibrate)
  - raise `seek_req` with `seek_cyl` showing the new cylinder until `seek_done` is pulsed.
- R6: Sense interrupt returns a single 0x80 and goes back to PH_CMD while a seek is pending. Otherwise it returns 0x20 and then the current cylinder, and it clears the request.
- R7: Read data and write data scan `sid_entry` records 0 to `sid_count`-1 for a record field equal to R. If none matches, the last record is used. A record is packed as C[47:40], H[39:32], R[31:24], N[23:16], ST1[15:8], ST2[7:0].
- R8: In read data execution, each data-port read returns `xfer_byte` and pulses `xfer_take`. After N×256 reads the block enters PH_RESULT.
- R9: The read or write data result is 7 bytes in this order: 0x00, ST1, ST2, C, H, R, N. After the 7th read the block is back in PH_CMD.
- R10: Read ID produces the same 7-byte result from record 0, with no execution phase.
- R11: A data-port read during execution of write data returns the block to PH_CMD.
- R12: Read data stays on `rdata` with `rdata_oe` high until `iorq_n` rises. A read advances the result index once, however long it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bus inputs are synchronous to it |
| rst_n | input | 1 | Active-low reset |
| iorq_n | input | 1 | Active-low I/O request strobe |
| wr | input | 1 | 1 = write cycle, 0 = read cycle |
| addr | input | 16 | I/O address |
| wdata | input | 8 | Write data from host |
| rdata | output | 8 | Read data to host |
| rdata_oe | output | 1 | Read data is being driven |
| seek_req | output | 1 | Seek posted and not yet completed |
| seek_cyl | output | 8 | Current (target) cylinder |
| seek_done | input | 1 | Pulse from the agent: seek finished |
| prev_cyl | output | 8 | Cylinder before the last seek |
| sid_count | input | 6 | Number of sector-ID records on the track |
| sid_idx | output | 5 | Index of the record being inspected |
| sid_entry | input | 48 | Record at `sid_idx` |
| xfer_byte | input | 8 | Sector byte returned in execution reads |
| xfer_take | output | 1 | One-cycle pulse per execution transfer |

## Verification
The command stream mixes opcodes that carry upper flag bits, an unsupported opcode, and a specify command followed directly by read ID. A misaligned byte counter would therefore show up as a wrong phase in a later status byte. Sense interrupt is tried in three situations: while the seek is pending, after done has been pulsed, and with nothing posted. These separate the one-byte and two-byte replies. Read data is run twice, once with an R that matches a middle record and once with an R that matches nothing, so the result bytes show which record was chosen. Write data, a held read strobe and decoys at foreign addresses cover the abort path, the single index advance and the address decode.

// File: rtl/fdc_emu_pkg.sv
package fdc_emu_pkg;

    typedef enum logic [1:0] {
        PH_CMD    = 2'd0,
        PH_LOOKUP = 2'd1,
        PH_EXEC   = 2'd2,
        PH_RESULT = 2'd3
    } phase_e;

    localparam logic [4:0] OP_SPECIFY  = 5'h03;
    localparam logic [4:0] OP_WRITE    = 5'h05;
    localparam logic [4:0] OP_READ     = 5'h06;
    localparam logic [4:0] OP_RECAL    = 5'h07;
    localparam logic [4:0] OP_SENSE    = 5'h08;
    localparam logic [4:0] OP_READ_ID  = 5'h0A;
    localparam logic [4:0] OP_SEEK     = 5'h0F;

    localparam logic [7:0] ST_CMD      = 8'h80;
    localparam logic [7:0] ST_RESULT   = 8'hD0;
    localparam logic [7:0] ST_BUSY     = 8'h00;
    localparam logic [7:0] ST_EXEC_RD  = 8'h50;
    localparam logic [7:0] ST_EXEC_WR  = 8'h10;
    localparam logic [7:0] ST_EXEC_RDY = 8'hA0;
    localparam logic [7:0] SNS_PENDING = 8'h80;
    localparam logic [7:0] SNS_DONE    = 8'h20;

    localparam int SEEK_CYL_BYTE = 2;
    localparam int REC_BYTE      = 4;
    localparam int RESULT_LAST   = 6;

    typedef struct packed {
        logic [7:0] cyl;
        logic [7:0] head;
        logic [7:0] rec;
        logic [7:0] size;
        logic [7:0] st1;
        logic [7:0] st2;
    } sector_id_t;

    function automatic logic [3:0] cmd_length(input logic [4:0] op);
        logic [3:0] len;
        case (op)
            OP_SPECIFY: len = 4'd3;
            OP_RECAL:   len = 4'd2;
            OP_SEEK:    len = 4'd3;
            OP_SENSE:   len = 4'd1;
            OP_READ:    len = 4'd9;
            OP_WRITE:   len = 4'd9;
            OP_READ_ID: len = 4'd2;
            default:    len = 4'd0;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/fdc_bus_port.sv
module fdc_bus_port #(
    parameter logic [7:0] BASE_HI = 8'hFB
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        iorq_n,
    input  logic        wr,
    input  logic [15:0] addr,
    input  logic [7:0]  rd_byte,
    output logic        acc_rd,
    output logic        acc_wr,
    output logic        acc_data,
    output logic [7:0]  rdata,
    output logic        rdata_oe
);

    logic iorq_q;
    logic hit;
    logic start;

    assign hit      = (addr[15:8] == BASE_HI) && (!addr[10] || !addr[8]);
    assign start    = iorq_q && !iorq_n && hit;
    assign acc_rd   = start && !wr;
    assign acc_wr   = start && wr;
    assign acc_data = addr[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iorq_q   <= 1'b1;
            rdata    <= 8'h00;
            rdata_oe <= 1'b0;
        end else begin
            iorq_q <= iorq_n;
            if (acc_rd) begin
                rdata    <= rd_byte;
                rdata_oe <= 1'b1;
            end else if (iorq_n) begin
                rdata_oe <= 1'b0;
            end
        end
    end

    assert_oe_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_oe && iorq_n) |=> !rdata_oe);

    assert_oe_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_oe && !iorq_n) |=> (rdata_oe && $stable(rdata)));

endmodule

// File: rtl/fdc_seek_link.sv
module fdc_seek_link (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       post,
    input  logic [7:0] new_cyl,
    input  logic       done_in,
    input  logic       clear,
    output logic       pending,
    output logic [7:0] cur_cyl,
    output logic [7:0] prev_cyl
);

    logic posted;
    logic complete;

    assign pending = posted && !complete;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            posted   <= 1'b0;
            complete <= 1'b0;
            cur_cyl  <= 8'h00;
            prev_cyl <= 8'h00;
        end else begin
            if (post) begin
                posted   <= 1'b1;
                complete <= 1'b0;
                prev_cyl <= cur_cyl;
                cur_cyl  <= new_cyl;
            end else if (clear) begin
                posted   <= 1'b0;
                complete <= 1'b0;
            end else if (done_in && posted) begin
                complete <= 1'b1;
            end
        end
    end

    assert_post_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        post |=> (pending && prev_cyl == $past(cur_cyl) && cur_cyl == $past(new_cyl)));

    assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !post) |=> !pending);

endmodule

// File: rtl/fdc_id_finder.sv
module fdc_id_finder
    import fdc_emu_pkg::*;
#(
    parameter int MAX_SECT = 32,
    parameter int IDX_W    = $clog2(MAX_SECT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             first_only,
    input  logic [7:0]       target,
    input  logic [IDX_W:0]   sid_count,
    output logic [IDX_W-1:0] sid_idx,
    input  sector_id_t       sid_entry,
    output logic             done,
    output sector_id_t       found
);

    logic             busy;
    logic             only_q;
    logic [7:0]       tgt_q;
    logic [IDX_W-1:0] idx;
    logic [IDX_W:0]   nxt;
    logic             last;
    logic             match;

    assign sid_idx = idx;
    assign nxt     = {1'b0, idx} + (IDX_W+1)'(1);
    assign last    = (nxt >= sid_count) || (idx == IDX_W'(MAX_SECT - 1));
    assign match   = only_q || (sid_entry.rec == tgt_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            only_q <= 1'b0;
            tgt_q  <= 8'h00;
            idx    <= '0;
            done   <= 1'b0;
            found  <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy   <= 1'b1;
                only_q <= first_only;
                tgt_q  <= target;
                idx    <= '0;
            end else if (busy) begin
                if (match || last) begin
                    found <= sid_entry;
                    done  <= 1'b1;
                    busy  <= 1'b0;
                end else begin
                    idx <= idx + IDX_W'(1);
                end
            end
        end
    end

    assert_scan_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (sid_count == '0 || {1'b0, idx} < sid_count));

    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: rtl/fdc_regs_emu.sv
module fdc_regs_emu
    import fdc_emu_pkg::*;
#(
    parameter logic [7:0] BASE_HI     = 8'hFB,
    parameter int         MAX_SECT    = 32,
    parameter int         DELAY_READS = 1,
    parameter int         IDX_W       = $clog2(MAX_SECT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iorq_n,
    input  logic             wr,
    input  logic [15:0]      addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic             rdata_oe,
    output logic             seek_req,
    output logic [7:0]       seek_cyl,
    input  logic             seek_done,
    output logic [7:0]       prev_cyl,
    input  logic [IDX_W:0]   sid_count,
    output logic [IDX_W-1:0] sid_idx,
    input  logic [47:0]      sid_entry,
    input  logic [7:0]       xfer_byte,
    output logic             xfer_take
);

    localparam int DLY_W = $clog2(DELAY_READS + 1);

    phase_e       phase;
    logic [4:0]   op_q;
    logic [3:0]   cmd_idx;
    logic [7:0]   rec_arg;
    logic [2:0]   res_idx;
    logic [15:0]  xfer_left;
    logic [DLY_W-1:0] delay_cnt;

    logic         acc_rd, acc_wr, acc_data;
    logic [7:0]   rd_byte;
    logic [4:0]   op_now;
    logic [3:0]   len_now;
    logic         final_byte;
    logic         cmd_wr, cmd_done;
    logic         seek_post;
    logic [7:0]   post_cyl;
    logic         find_start, find_done;
    sector_id_t   found;
    logic         res_rd;
    logic         sense_clear;
    logic         pending;
    logic [7:0]   cur_cyl;
    logic         seven_byte;

    fdc_bus_port #(.BASE_HI(BASE_HI)) u_port (
        .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .wr(wr), .addr(addr),
        .rd_byte(rd_byte), .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_data(acc_data),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

    fdc_seek_link u_seek (
        .clk(clk), .rst_n(rst_n), .post(seek_post), .new_cyl(post_cyl),
        .done_in(seek_done), .clear(sense_clear), .pending(pending),
        .cur_cyl(cur_cyl), .prev_cyl(prev_cyl)
    );

    fdc_id_finder #(.MAX_SECT(MAX_SECT), .IDX_W(IDX_W)) u_find (
        .clk(clk), .rst_n(rst_n), .start(find_start),
        .first_only(op_now == OP_READ_ID), .target(rec_arg),
        .sid_count(sid_count), .sid_idx(sid_idx), .sid_entry(sector_id_t'(sid_entry)),
        .done(find_done), .found(found)
    );

    assign seek_req = pending;
    assign seek_cyl = cur_cyl;

    // Command decoding
    assign op_now     = (cmd_idx == 4'd0) ? wdata[4:0] : op_q;
    assign len_now    = cmd_length(op_now);
    assign final_byte = (len_now != 4'd0) && (cmd_idx + 4'd1 == len_now);
    assign cmd_wr     = acc_wr && acc_data && (phase == PH_CMD);
    assign cmd_done   = cmd_wr && final_byte;
    assign seek_post  = cmd_done && (op_now == OP_SEEK || op_now == OP_RECAL);
    assign post_cyl   = (op_now == OP_SEEK) ? wdata : 8'h00;
    assign find_start = cmd_done &&
                        (op_now == OP_READ || op_now == OP_WRITE || op_now == OP_READ_ID);
    assign seven_byte = (op_q == OP_READ || op_q == OP_WRITE || op_q == OP_READ_ID);
    assign res_rd     = acc_rd && acc_data && (phase == PH_RESULT);
    assign sense_clear = res_rd && (op_q == OP_SENSE) && (res_idx == 3'd0) && !pending;

    function automatic logic [7:0] result_byte(input sector_id_t e, input logic [2:0] i);
        logic [7:0] b;
        case (i)
            3'd0:    b = 8'h00;
            3'd1:    b = e.st1;
            3'd2:    b = e.st2;
            3'd3:    b = e.cyl;
            3'd4:    b = e.head;
            3'd5:    b = e.rec;
            default: b = e.size;
        endcase
        return b;
    endfunction

    // Output process: byte presented to the bus port
    always_comb begin
        rd_byte = 8'h00;
        if (!acc_data) begin
            unique case (phase)
                PH_CMD:    rd_byte = ST_CMD;
                PH_LOOKUP: rd_byte = ST_BUSY;
                PH_RESULT: rd_byte = ST_RESULT;
                PH_EXEC:   rd_byte = ((op_q == OP_WRITE) ? ST_EXEC_WR : ST_EXEC_RD) |
                                     ((delay_cnt == '0) ? ST_EXEC_RDY : 8'h00);
            endcase
        end else begin
            unique case (phase)
                PH_CMD:    rd_byte = 8'h00;
                PH_LOOKUP: rd_byte = 8'h00;
                PH_EXEC:   rd_byte = (op_q == OP_READ) ? xfer_byte : 8'h00;
                PH_RESULT: begin
                    if (op_q == OP_SENSE)
                        rd_byte = (res_idx == 3'd0) ? (pending ? SNS_PENDING : SNS_DONE)
                                                    : cur_cyl;
                    else
                        rd_byte = result_byte(found, res_idx);
                end
            endcase
        end
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase     <= PH_CMD;
            op_q      <= 5'h00;
            cmd_idx   <= 4'd0;
            rec_arg   <= 8'h00;
            res_idx   <= 3'd0;
            xfer_left <= 16'h0000;
            delay_cnt <= '0;
            xfer_take <= 1'b0;
        end else begin
            xfer_take <= 1'b0;
            unique case (phase)
                PH_CMD: begin
                    if (cmd_wr && len_now != 4'd0) begin
                        if (cmd_idx == 4'd0) op_q <= wdata[4:0];
                        if (cmd_idx == 4'(REC_BYTE)) rec_arg <= wdata;
                        if (final_byte) begin
                            cmd_idx <= 4'd0;
                            if (op_now == OP_SENSE) begin        // CMD_TO_RESULT
                                phase   <= PH_RESULT;
                                res_idx <= 3'd0;
                            end else if (find_start) begin       // CMD_TO_LOOKUP
                                phase <= PH_LOOKUP;
                            end
                        end else begin
                            cmd_idx <= cmd_idx + 4'd1;
                        end
                    end
                end
                PH_LOOKUP: begin
                    if (find_done) begin
                        res_idx <= 3'd0;
                        if (op_q == OP_READ_ID) begin            // LOOKUP_TO_RESULT
                            phase <= PH_RESULT;
                        end else begin                           // LOOKUP_TO_EXEC
                            phase     <= PH_EXEC;
                            xfer_left <= {found.size, 8'h00};
                            delay_cnt <= DLY_W'(DELAY_READS);
                        end
                    end
                end
                PH_EXEC: begin
                    if (acc_rd && !acc_data) begin
                        if (delay_cnt != '0) delay_cnt <= delay_cnt - DLY_W'(1);
                    end else if ((acc_rd && acc_data && op_q == OP_READ) ||
                                 (acc_wr && acc_data && op_q == OP_WRITE)) begin
                        xfer_take <= 1'b1;
                        xfer_left <= xfer_left - 16'd1;
                        if (xfer_left <= 16'd1) begin            // EXEC_TO_RESULT
                            phase   <= PH_RESULT;
                            res_idx <= 3'd0;
                        end
                    end else if (acc_rd && acc_data) begin       // EXEC_ABORT
                        phase <= PH_CMD;
                    end
                end
                PH_RESULT: begin
                    if (res_rd) begin
                        if (op_q == OP_SENSE) begin
                            if (res_idx == 3'd0 && !pending) res_idx <= 3'd1;
                            else phase <= PH_CMD;                // RESULT_TO_CMD
                        end else if (seven_byte) begin
                            if (res_idx == 3'(RESULT_LAST)) phase <= PH_CMD;
                            else res_idx <= res_idx + 3'd1;
                        end else begin
                            phase <= PH_CMD;
                        end
                    end
                end
            endcase
        end
    end

    assert_cmd_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> (cmd_idx == 4'd0));

    assert_lookup_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOOKUP && acc_rd && !acc_data) |=> (rdata == ST_BUSY));

    assert_first_exec_plain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC && delay_cnt != '0 && acc_rd && !acc_data) |=> ((rdata & ST_EXEC_RDY) == 8'h00));

    assert_exec_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC) |-> (op_q == OP_READ || op_q == OP_WRITE));

    assert_result_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_rd && seven_byte && res_idx == 3'(RESULT_LAST)) |=> (phase == PH_CMD));

    assert_write_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC && op_q == OP_WRITE && acc_rd && acc_data) |=> (phase == PH_CMD));

endmodule

// File: tb/test_fdc_regs_emu.sv
module test_fdc_regs_emu;

    localparam int NV = 45;
    localparam logic [15:0] A_ST = 16'hFB7E;
    localparam logic [15:0] A_DT = 16'hFB7F;
    localparam int IDLE = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iorq_n = 1'b1;
    logic        wr = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        rdata_oe;
    logic        seek_req;
    logic [7:0]  seek_cyl;
    logic        seek_done = 1'b0;
    logic [7:0]  prev_cyl;
    logic [5:0]  sid_count = 6'd4;
    logic [4:0]  sid_idx;
    logic [47:0] sid_entry;
    logic [7:0]  xfer_byte = 8'h00;
    logic        xfer_take;

    int checks = 0;
    int errors = 0;
    int takes  = 0;
    bit over   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    fdc_regs_emu i_fdc_regs_emu (
        .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .seek_req(seek_req),
        .seek_cyl(seek_cyl), .seek_done(seek_done), .prev_cyl(prev_cyl),
        .sid_count(sid_count), .sid_idx(sid_idx), .sid_entry(sid_entry),
        .xfer_byte(xfer_byte), .xfer_take(xfer_take)
    );

    // Track model: record i has C=07 H=00 R=C1+i N=01 ST1=10+i ST2=20+i
    function automatic logic [47:0] sect(input int i);
        return {8'h07, 8'h00, 8'(8'hC1 + i), 8'h01, 8'(8'h10 + i), 8'(8'h20 + i)};
    endfunction
    always_comb sid_entry = (int'(sid_idx) < 4) ? sect(int'(sid_idx)) : 48'h0;

    always @(posedge clk) if (xfer_take) takes <= takes + 1;

    // Row: act, wr, port, data, chk, req
    function automatic logic [15:0] mk(input bit act, input bit w, input bit p,
                                       input logic [7:0] d, input bit c, input int r);
        return {act, w, p, d, c, 4'(r)};
    endfunction

    localparam logic [15:0] VEC [NV] = '{
        mk(0,0,0,8'h80,1,3),   // R3 idle status
        mk(0,1,1,8'h0F,0,2),   // seek opcode
        mk(0,0,0,8'h80,1,3),   // R3 mid-command
        mk(0,1,1,8'h00,0,2),
        mk(0,1,1,8'h05,0,5),   // cylinder 5 -> R5 post
        mk(0,1,1,8'h08,0,6),   // sense interrupt
        mk(0,0,0,8'hD0,1,3),   // R3 result phase
        mk(0,0,1,8'h80,1,6),   // R6 pending -> single byte
        mk(0,0,0,8'h80,1,6),   // R6 back to command
        mk(0,1,1,8'h08,0,6),
        mk(1,0,1,8'h20,1,6),   // R6 done pulsed first
        mk(0,0,1,8'h05,1,6),   // R6 cylinder
        mk(0,0,0,8'h80,1,6),
        mk(0,1,1,8'h08,0,6),   // nothing posted
        mk(0,0,1,8'h20,1,6),   // R6
        mk(0,0,1,8'h05,1,6),   // R6
        mk(0,1,1,8'h1F,0,2),   // R2 unsupported opcode
        mk(0,0,0,8'h80,1,2),   // R2
        mk(0,1,1,8'h03,0,2),   // specify
        mk(0,1,1,8'hAF,0,2),
        mk(0,1,1,8'h02,0,2),
        mk(0,0,0,8'h80,1,2),   // R2 specify complete
        mk(0,1,1,8'h4A,0,10),  // read ID with flag bit (R2 mask)
        mk(0,1,1,8'h00,0,10),
        mk(0,0,0,8'hD0,1,10),  // R10 straight to result
        mk(0,0,1,8'h00,1,10),  // R10 record 0 bytes
        mk(0,0,1,8'h10,1,10),
        mk(0,0,1,8'h20,1,10),
        mk(0,0,1,8'h07,1,10),
        mk(0,0,1,8'h00,1,10),
        mk(0,0,1,8'hC1,1,10),
        mk(0,0,1,8'h01,1,10),
        mk(0,0,0,8'h80,1,9),   // R9 back to command
        mk(0,1,1,8'h46,0,7),   // read data, R=C3
        mk(0,1,1,8'h00,0,7),
        mk(0,1,1,8'h07,0,7),
        mk(0,1,1,8'h00,0,7),
        mk(0,1,1,8'hC3,0,7),
        mk(0,1,1,8'h01,0,7),
        mk(0,1,1,8'hC4,0,7),
        mk(0,1,1,8'h2A,0,7),
        mk(0,1,1,8'hFF,0,7),
        mk(0,0,0,8'h50,1,4),   // R4 first exec status
        mk(0,0,0,8'hF0,1,4),   // R4 ready bits
        mk(0,0,0,8'hF0,1,4)    // R4
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic w, input logic [15:0] a, input logic [7:0] d,
                       output logic [7:0] q, output logic oe);
        @(negedge clk);
        addr = a; wr = w; wdata = d; iorq_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        q = rdata; oe = rdata_oe;
        iorq_n = 1'b1;
        repeat (IDLE) @(negedge clk);
    endtask

    task automatic put(input logic [7:0] d);
        logic [7:0] q; logic oe;
        bus(1'b1, A_DT, d, q, oe);
    endtask

    task automatic get(input logic [15:0] a, output logic [7:0] q);
        logic oe;
        bus(1'b0, a, 8'h00, q, oe);
    endtask

    task automatic pulse_done();
        @(negedge clk); seek_done = 1'b1;
        @(negedge clk); seek_done = 1'b0;
    endtask

    task automatic read_cmd(input logic [7:0] op, input logic [7:0] r);
        put(op); put(8'h00); put(8'h07); put(8'h00); put(r);
        put(8'h01); put(r); put(8'h2A); put(8'hFF);
    endtask

    task automatic drain_exec(input string tag);
        logic [7:0] q;
        int t0;
        t0 = takes;
        for (int k = 0; k < 256; k++) begin
            xfer_byte = 8'(k) ^ 8'h3C;
            get(A_DT, q);
            if (q !== (8'(k) ^ 8'h3C)) check(tag, q, 8'(k) ^ 8'h3C);
        end
        checks++;
        if (takes - t0 != 256) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=256 transfers", tag, takes - t0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!over) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] q;
        logic oe;
        logic [15:0] row;
        logic [7:0] exp7 [7];

        repeat (3) @(negedge clk);
        // reset state
        check("R12 reset oe", {7'd0, rdata_oe}, 8'h00);
        check("R5 reset req", {7'd0, seek_req}, 8'h00);
        check("R5 reset prev", prev_cyl, 8'h00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            row = VEC[i];
            if (row[15]) pulse_done();
            bus(row[14], row[13] ? A_DT : A_ST, row[12:5], q, oe);
            if (row[4]) check($sformatf("R%0d row %0d", row[3:0], i), q, row[12:5]);
        end

        // R8 transfer phase, then R9/R7 result from matching record 2
        drain_exec("R8");
        get(A_ST, q); check("R8 result status", q, 8'hD0);
        exp7 = '{8'h00, 8'h12, 8'h22, 8'h07, 8'h00, 8'hC3, 8'h01};
        for (int k = 0; k < 7; k++) begin
            get(A_DT, q); check($sformatf("R9 byte %0d", k), q, exp7[k]);
        end
        get(A_ST, q); check("R9 back to command", q, 8'h80);

        // R7 no matching record -> last record 3
        read_cmd(8'h06, 8'h99);
        drain_exec("R8 second");
        exp7 = '{8'h00, 8'h13, 8'h23, 8'h07, 8'h00, 8'hC4, 8'h01};
        for (int k = 0; k < 7; k++) begin
            get(A_DT, q); check($sformatf("R7 fallback byte %0d", k), q, exp7[k]);
        end

        // R4 write data statuses, R11 abort on data read
        read_cmd(8'h45, 8'hC2);
        get(A_ST, q); check("R4 write first", q, 8'h10);
        get(A_ST, q); check("R4 write ready", q, 8'hB0);
        get(A_DT, q);
        get(A_ST, q); check("R11 abort to command", q, 8'h80);

        // R5 recalibrate
        put(8'h07); put(8'h00);
        check("R5 req", {7'd0, seek_req}, 8'h01);
        check("R5 target", seek_cyl, 8'h00);
        check("R5 prev", prev_cyl, 8'h05);
        put(8'h08);
        get(A_DT, q); check("R6 pending after recal", q, 8'h80);
        pulse_done();
        check("R5 req dropped on done", {7'd0, seek_req}, 8'h00);
        put(8'h08);
        get(A_DT, q); check("R6 done byte", q, 8'h20);
        get(A_DT, q); check("R6 cylinder 0", q, 8'h00);

        // R1 decode: foreign addresses
        bus(1'b0, 16'hFA7E, 8'h00, q, oe);
        check("R1 foreign read oe", {7'd0, oe}, 8'h00);
        bus(1'b1, 16'hFF7F, 8'h08, q, oe);
        bus(1'b1, A_ST, 8'h08, q, oe);
        get(A_ST, q); check("R1 ignored writes", q, 8'h80);

        // R12 held read advances once
        put(8'h0A); put(8'h00);
        @(negedge clk);
        addr = A_DT; wr = 1'b0; iorq_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            check("R12 held data", rdata, 8'h00);
            check("R12 held oe", {7'd0, rdata_oe}, 8'h01);
            @(negedge clk);
        end
        iorq_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R12 released oe", {7'd0, rdata_oe}, 8'h00);
        repeat (IDLE) @(negedge clk);
        get(A_DT, q); check("R12 single advance", q, 8'h10);
        for (int k = 0; k < 5; k++) get(A_DT, q);
        get(A_ST, q); check("R9 after read ID", q, 8'h80);

        over = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule